// File: doc/BRIEF.md
# Dual-Operand Effective Address Generator

This block turns the addressing fields of a two-operand load/store instruction into memory addresses for a 16-bit datapath. It holds sixteen 16-bit working registers. The source operand and the destination operand each have their own mode, base register, modify direction, signed literal and direct address. Both operands share one offset-register index. In a single cycle the block produces both effective addresses, a flag for each that says whether a memory address exists, the raw base-register value, and the base-register update that each operand asks for.

The addresses and update values are combinational from the current register contents. An update is written into the register file on the rising clock edge when the execute strobe is high. A separate test port writes any register directly. This port loads pointers and sets up corner cases without an instruction stream.

Top module: `ea_gen_top`

## Requirements
- R1: Mode code 2 (indirect) gives EA = base register. Mode code 0 (direct address) gives EA = the operand's 16-bit address field. Both set the valid flag and request no update.
- R2: Mode code 3 (post-modify) gives EA = base register before the change, and requests an update of base + step.
- R3: Mode code 4 (pre-modify) gives EA = base + step, and requests an update of the base register with that same value.
- R4: Mode code 5 (indexed) gives EA = base + the register selected by the shared offset index. Source and destination read the same offset register.
- R5: Mode code 6 (literal offset) gives EA = base + the literal, sign-extended from its width to 16 bits. All address sums wrap modulo 2^16.
- R6: Mode code 1 (register) and the unused code 7 clear the valid flag and request no update. The base-register value appears on the rval output in every mode.
- R7: The step is 2 when byte_op is 0 and 1 when byte_op is 1. It is negated when the operand's dec bit is 1.
- R8: If both operands request an update of the same register, wb_conflict is 1 and only the destination value is written.
- R9: Requested updates are written only on a clock edge with exec_en high. Otherwise the registers keep their values.
- R10: A test-port write on the same edge overrides any update to that register.
- R11: After reset, all registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_en | input | 1 | Commit requested updates on this edge |
| byte_op | input | 1 | 1 = byte-sized step, 0 = word-sized step |
| off_idx | input | 4 | Shared offset register index |
| src_mode | input | 3 | Source addressing mode code |
| src_base | input | 4 | Source base register index |
| src_dec | input | 1 | Source modify direction (1 = subtract) |
| src_lit | input | 6 | Source signed literal offset |
| src_faddr | input | 16 | Source direct address field |
| dst_mode | input | 3 | Destination addressing mode code |
| dst_base | input | 4 | Destination base register index |
| dst_dec | input | 1 | Destination modify direction |
| dst_lit | input | 6 | Destination signed literal offset |
| dst_faddr | input | 16 | Destination direct address field |
| tw_en | input | 1 | Test-port register write enable |
| tw_idx | input | 4 | Test-port register index |
| tw_data | input | 16 | Test-port write data |
| src_ea | output | 16 | Source effective address |
| src_ea_vld | output | 1 | Source produces a memory address |
| src_rval | output | 16 | Source base register value |
| src_wb_req | output | 1 | Source requests a base update |
| src_wb_val | output | 16 | Source base update value |
| dst_ea | output | 16 | Destination effective address |
| dst_ea_vld | output | 1 | Destination produces a memory address |
| dst_rval | output | 16 | Destination base register value |
| dst_wb_req | output | 1 | Destination requests a base update |
| dst_wb_val | output | 16 | Destination base update value |
| wb_conflict | output | 1 | Both operands request an update of one register |

## Verification
The hardest case to reach from the ports is a commit where both operands modify the same register, possibly on the same edge as a test-port write to it. Uniform random indices reach this case only about one time in sixteen among the modifying modes. The random stimulus therefore often narrows base, offset and test indices to four registers. Directed vectors also place post- and pre-modify on one base. Pointers are preloaded near 0x0000 and 0xFFFF so that wrap-around and negative literals occur.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [2:0] {
    AM_FADDR  = 3'd0,
    AM_REG    = 3'd1,
    AM_IND    = 3'd2,
    AM_POSTM  = 3'd3,
    AM_PREM   = 3'd4,
    AM_INDEX  = 3'd5,
    AM_LITOFS = 3'd6,
    AM_NONE   = 3'd7
  } amode_e;

  localparam int unsigned WORD_STEP = 2;
  localparam int unsigned BYTE_STEP = 1;
endpackage

// File: rtl/ea_operand.sv
module ea_operand
  import ea_pkg::*;
#(
  parameter int W    = 16,
  parameter int LITW = 6
) (
  input  logic [2:0]      mode,
  input  logic [W-1:0]    base_val,
  input  logic [W-1:0]    off_val,
  input  logic [LITW-1:0] lit,
  input  logic [W-1:0]    faddr,
  input  logic            byte_op,
  input  logic            dec,
  output logic [W-1:0]    ea,
  output logic            ea_vld,
  output logic            wb_req,
  output logic [W-1:0]    wb_val,
  output logic [W-1:0]    rval
);

  function automatic logic [W-1:0] step_of(input logic b, input logic d);
    logic [W-1:0] s;
    s = b ? W'(BYTE_STEP) : W'(WORD_STEP);
    return d ? (~s + W'(1)) : s;
  endfunction

  function automatic logic [W-1:0] sext_lit(input logic [LITW-1:0] l);
    return {{(W-LITW){l[LITW-1]}}, l};
  endfunction

  logic [W-1:0] delta;
  logic [W-1:0] modified;
  amode_e       am;

  assign am       = amode_e'(mode);
  assign delta    = step_of(byte_op, dec);
  assign modified = base_val + delta;
  assign rval     = base_val;

  always_comb begin
    ea     = '0;
    ea_vld = 1'b0;
    wb_req = 1'b0;
    wb_val = modified;
    unique case (am)
      AM_FADDR: begin
        ea     = faddr;
        ea_vld = 1'b1;
      end
      AM_IND: begin
        ea     = base_val;
        ea_vld = 1'b1;
      end
      AM_POSTM: begin
        ea     = base_val;
        ea_vld = 1'b1;
        wb_req = 1'b1;
      end
      AM_PREM: begin
        ea     = modified;
        ea_vld = 1'b1;
        wb_req = 1'b1;
      end
      AM_INDEX: begin
        ea     = base_val + off_val;
        ea_vld = 1'b1;
      end
      AM_LITOFS: begin
        ea     = base_val + sext_lit(lit);
        ea_vld = 1'b1;
      end
      default: begin
        ea     = '0;
        ea_vld = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/ea_wb_arb.sv
module ea_wb_arb #(
  parameter int W    = 16,
  parameter int IDXW = 4
) (
  input  logic            exec_en,
  input  logic            s_req,
  input  logic [IDXW-1:0] s_idx,
  input  logic [W-1:0]    s_val,
  input  logic            d_req,
  input  logic [IDXW-1:0] d_idx,
  input  logic [W-1:0]    d_val,
  output logic            a_en,
  output logic [IDXW-1:0] a_idx,
  output logic [W-1:0]    a_val,
  output logic            b_en,
  output logic [IDXW-1:0] b_idx,
  output logic [W-1:0]    b_val,
  output logic            conflict
);

  assign conflict = s_req && d_req && (s_idx == d_idx);

  assign a_en  = exec_en && s_req && !conflict;
  assign a_idx = s_idx;
  assign a_val = s_val;

  assign b_en  = exec_en && d_req;
  assign b_idx = d_idx;
  assign b_val = d_val;

endmodule

// File: rtl/ea_regfile.sv
module ea_regfile #(
  parameter int W    = 16,
  parameter int NREG = 16,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tw_en,
  input  logic [IDXW-1:0]           tw_idx,
  input  logic [W-1:0]              tw_data,
  input  logic                      a_en,
  input  logic [IDXW-1:0]           a_idx,
  input  logic [W-1:0]              a_val,
  input  logic                      b_en,
  input  logic [IDXW-1:0]           b_idx,
  input  logic [W-1:0]              b_val,
  output logic [NREG-1:0][W-1:0]    rf_q
);

  logic [NREG-1:0][W-1:0] rf_d;

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      rf_d[i] = rf_q[i];
      if (a_en && a_idx == IDXW'(i)) rf_d[i] = a_val;
      if (b_en && b_idx == IDXW'(i)) rf_d[i] = b_val;
      if (tw_en && tw_idx == IDXW'(i)) rf_d[i] = tw_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rf_q <= '0;
    else        rf_q <= rf_d;
  end

endmodule

// File: rtl/ea_gen_top.sv
module ea_gen_top #(
  parameter int W    = 16,
  parameter int NREG = 16,
  parameter int LITW = 6,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exec_en,
  input  logic            byte_op,
  input  logic [IDXW-1:0] off_idx,
  input  logic [2:0]      src_mode,
  input  logic [IDXW-1:0] src_base,
  input  logic            src_dec,
  input  logic [LITW-1:0] src_lit,
  input  logic [W-1:0]    src_faddr,
  input  logic [2:0]      dst_mode,
  input  logic [IDXW-1:0] dst_base,
  input  logic            dst_dec,
  input  logic [LITW-1:0] dst_lit,
  input  logic [W-1:0]    dst_faddr,
  input  logic            tw_en,
  input  logic [IDXW-1:0] tw_idx,
  input  logic [W-1:0]    tw_data,
  output logic [W-1:0]    src_ea,
  output logic            src_ea_vld,
  output logic [W-1:0]    src_rval,
  output logic            src_wb_req,
  output logic [W-1:0]    src_wb_val,
  output logic [W-1:0]    dst_ea,
  output logic            dst_ea_vld,
  output logic [W-1:0]    dst_rval,
  output logic            dst_wb_req,
  output logic [W-1:0]    dst_wb_val,
  output logic            wb_conflict
);

  logic [NREG-1:0][W-1:0] rf_q;
  logic [W-1:0]           off_val;
  logic                   a_en, b_en;
  logic [IDXW-1:0]        a_idx, b_idx;
  logic [W-1:0]           a_val, b_val;

  assign off_val = rf_q[off_idx];

  ea_operand #(.W(W), .LITW(LITW)) u_src (
    .mode(src_mode), .base_val(rf_q[src_base]), .off_val(off_val),
    .lit(src_lit), .faddr(src_faddr), .byte_op(byte_op), .dec(src_dec),
    .ea(src_ea), .ea_vld(src_ea_vld), .wb_req(src_wb_req),
    .wb_val(src_wb_val), .rval(src_rval)
  );

  ea_operand #(.W(W), .LITW(LITW)) u_dst (
    .mode(dst_mode), .base_val(rf_q[dst_base]), .off_val(off_val),
    .lit(dst_lit), .faddr(dst_faddr), .byte_op(byte_op), .dec(dst_dec),
    .ea(dst_ea), .ea_vld(dst_ea_vld), .wb_req(dst_wb_req),
    .wb_val(dst_wb_val), .rval(dst_rval)
  );

  ea_wb_arb #(.W(W), .IDXW(IDXW)) u_arb (
    .exec_en(exec_en),
    .s_req(src_wb_req), .s_idx(src_base), .s_val(src_wb_val),
    .d_req(dst_wb_req), .d_idx(dst_base), .d_val(dst_wb_val),
    .a_en(a_en), .a_idx(a_idx), .a_val(a_val),
    .b_en(b_en), .b_idx(b_idx), .b_val(b_val),
    .conflict(wb_conflict)
  );

  ea_regfile #(.W(W), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .tw_en(tw_en), .tw_idx(tw_idx), .tw_data(tw_data),
    .a_en(a_en), .a_idx(a_idx), .a_val(a_val),
    .b_en(b_en), .b_idx(b_idx), .b_val(b_val),
    .rf_q(rf_q)
  );

endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int W    = 16,
  parameter int NREG = 16,
  localparam int IDXW = $clog2(NREG)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   exec_en,
  input logic                   tw_en,
  input logic [IDXW-1:0]        tw_idx,
  input logic [W-1:0]           tw_data,
  input logic [2:0]             src_mode,
  input logic [IDXW-1:0]        src_base,
  input logic [W-1:0]           src_ea,
  input logic                   src_ea_vld,
  input logic                   src_wb_req,
  input logic [2:0]             dst_mode,
  input logic [IDXW-1:0]        dst_base,
  input logic                   dst_wb_req,
  input logic [W-1:0]           dst_wb_val,
  input logic                   wb_conflict,
  input logic [NREG-1:0][W-1:0] rf_q
);

  logic tw_hits_dst;
  logic tw_hits_src;
  assign tw_hits_dst = tw_en && (tw_idx == dst_base);
  assign tw_hits_src = tw_en && (tw_idx == src_base);

  // R11
  reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rf_q == '0));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_en && !tw_en) |=> $stable(rf_q));

  // R10
  tw_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tw_en |=> (rf_q[$past(tw_idx)] == $past(tw_data)));

  // R8
  conflict_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && wb_conflict && !tw_hits_dst) |=> (rf_q[$past(dst_base)] == $past(dst_wb_val)));

  // R2
  post_ea_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_mode == 3'd3) |-> (src_ea == rf_q[src_base] && src_wb_req));

  // R3
  pre_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && src_mode == 3'd4 && !wb_conflict && !tw_hits_src)
      |=> (rf_q[$past(src_base)] == $past(src_ea)));

  // R6
  reg_noaddr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_mode == 3'd1 || src_mode == 3'd7) |-> (!src_ea_vld && !src_wb_req));

  // R8
  conflict_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_conflict |-> (src_wb_req && dst_wb_req && src_base == dst_base
                     && (dst_mode == 3'd3 || dst_mode == 3'd4)));

endmodule

bind ea_gen_top ea_gen_chk #(.W(W), .NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .exec_en(exec_en),
  .tw_en(tw_en), .tw_idx(tw_idx), .tw_data(tw_data),
  .src_mode(src_mode), .src_base(src_base), .src_ea(src_ea),
  .src_ea_vld(src_ea_vld), .src_wb_req(src_wb_req),
  .dst_mode(dst_mode), .dst_base(dst_base), .dst_wb_req(dst_wb_req),
  .dst_wb_val(dst_wb_val), .wb_conflict(wb_conflict), .rf_q(rf_q)
);

// File: tb/sim_ea_gen_top.sv
module sim_ea_gen_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exec_en = 0, byte_op = 0, src_dec = 0, dst_dec = 0, tw_en = 0;
  logic [3:0] off_idx = 0, src_base = 0, dst_base = 0, tw_idx = 0;
  logic [2:0] src_mode = 3'd1, dst_mode = 3'd1;
  logic [5:0] src_lit = 0, dst_lit = 0;
  logic [15:0] src_faddr = 0, dst_faddr = 0, tw_data = 0;
  logic [15:0] src_ea, src_rval, src_wb_val, dst_ea, dst_rval, dst_wb_val;
  logic src_ea_vld, src_wb_req, dst_ea_vld, dst_wb_req, wb_conflict;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] m_rf [16];
  logic [15:0] m_nx [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  ea_gen_top u0 (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .byte_op(byte_op), .off_idx(off_idx),
    .src_mode(src_mode), .src_base(src_base), .src_dec(src_dec), .src_lit(src_lit),
    .src_faddr(src_faddr), .dst_mode(dst_mode), .dst_base(dst_base), .dst_dec(dst_dec),
    .dst_lit(dst_lit), .dst_faddr(dst_faddr), .tw_en(tw_en), .tw_idx(tw_idx),
    .tw_data(tw_data), .src_ea(src_ea), .src_ea_vld(src_ea_vld), .src_rval(src_rval),
    .src_wb_req(src_wb_req), .src_wb_val(src_wb_val), .dst_ea(dst_ea),
    .dst_ea_vld(dst_ea_vld), .dst_rval(dst_rval), .dst_wb_req(dst_wb_req),
    .dst_wb_val(dst_wb_val), .wb_conflict(wb_conflict)
  );

  function automatic string mtag(input logic [2:0] m);
    case (m)
      3'd0, 3'd2: return "R1";
      3'd3: return "R2";
      3'd4: return "R3";
      3'd5: return "R4";
      3'd6: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [15:0] x_step(input logic b, input logic d);
    int s;
    s = b ? 1 : 2;
    if (d) s = -s;
    return 16'(s);
  endfunction

  function automatic logic [15:0] x_ea(input logic [2:0] m, input logic [15:0] wn,
      input logic [15:0] wb, input logic [5:0] l, input logic [15:0] fa,
      input logic b, input logic d);
    int lv;
    lv = $signed(l);
    case (m)
      3'd0: return fa;
      3'd2, 3'd3: return wn;
      3'd4: return wn + x_step(b, d);
      3'd5: return 16'((32'(wn) + 32'(wb)) % 65536);
      3'd6: return 16'(int'(wn) + lv);
      default: return 16'h0;
    endcase
  endfunction

  function automatic logic x_vld(input logic [2:0] m);
    return !(m == 3'd1 || m == 3'd7);
  endfunction

  function automatic logic x_wb(input logic [2:0] m);
    return (m == 3'd3 || m == 3'd4);
  endfunction

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Inputs are already set after a negedge; check outputs, build the next model state.
  task automatic check_now(input string rtag);
    logic sw, dw, conf;
    logic [15:0] sv, dv;
    sw = x_wb(src_mode);
    dw = x_wb(dst_mode);
    conf = sw && dw && (src_base == dst_base);
    sv = m_rf[src_base] + x_step(byte_op, src_dec);
    dv = m_rf[dst_base] + x_step(byte_op, dst_dec);
    chk(src_ea_vld == x_vld(src_mode), mtag(src_mode), "src_ea_vld", 32'(src_ea_vld), 32'(x_vld(src_mode)));
    if (x_vld(src_mode))
      chk(src_ea == x_ea(src_mode, m_rf[src_base], m_rf[off_idx], src_lit, src_faddr, byte_op, src_dec),
          mtag(src_mode), "src_ea", 32'(src_ea),
          32'(x_ea(src_mode, m_rf[src_base], m_rf[off_idx], src_lit, src_faddr, byte_op, src_dec)));
    chk(dst_ea_vld == x_vld(dst_mode), mtag(dst_mode), "dst_ea_vld", 32'(dst_ea_vld), 32'(x_vld(dst_mode)));
    if (x_vld(dst_mode))
      chk(dst_ea == x_ea(dst_mode, m_rf[dst_base], m_rf[off_idx], dst_lit, dst_faddr, byte_op, dst_dec),
          mtag(dst_mode), "dst_ea", 32'(dst_ea),
          32'(x_ea(dst_mode, m_rf[dst_base], m_rf[off_idx], dst_lit, dst_faddr, byte_op, dst_dec)));
    chk(src_rval == m_rf[src_base], rtag, "src_rval", 32'(src_rval), 32'(m_rf[src_base]));
    chk(dst_rval == m_rf[dst_base], rtag, "dst_rval", 32'(dst_rval), 32'(m_rf[dst_base]));
    chk(src_wb_req == sw && dst_wb_req == dw, "R7", "wb_req", {src_wb_req, dst_wb_req}, {sw, dw});
    if (sw) chk(src_wb_val == sv, "R7", "src_wb_val", 32'(src_wb_val), 32'(sv));
    if (dw) chk(dst_wb_val == dv, "R7", "dst_wb_val", 32'(dst_wb_val), 32'(dv));
    chk(wb_conflict == conf, "R8", "wb_conflict", 32'(wb_conflict), 32'(conf));
    for (int i = 0; i < 16; i++) m_nx[i] = m_rf[i];
    if (exec_en && sw && !conf) m_nx[src_base] = sv;
    if (exec_en && dw) m_nx[dst_base] = dv;
    if (tw_en) m_nx[tw_idx] = tw_data;
  endtask

  task automatic step_vec(input string rtag);
    #1;
    check_now(rtag);
    @(posedge clk);
    for (int i = 0; i < 16; i++) m_rf[i] = m_nx[i];
    @(negedge clk);
  endtask

  task automatic idle_in();
    exec_en = 0; tw_en = 0; byte_op = 0; src_dec = 0; dst_dec = 0;
    src_mode = 3'd1; dst_mode = 3'd1; src_lit = 0; dst_lit = 0;
  endtask

  task automatic load(input logic [3:0] r, input logic [15:0] v);
    idle_in();
    tw_en = 1; tw_idx = r; tw_data = v;
    step_vec("R10");
  endtask

  task automatic readreg(input logic [3:0] r, input string tag);
    idle_in();
    src_base = r; dst_base = r;
    step_vec(tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) m_rf[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11: every register reads zero after reset
    for (int r = 0; r < 16; r++) readreg(4'(r), "R11");

    // R2/R7: post-modify word increment with wrap from 0xFFFF
    load(4'd3, 16'hFFFF);
    idle_in(); exec_en = 1; src_mode = 3'd3; src_base = 4'd3; dst_mode = 3'd1; dst_base = 4'd4;
    step_vec("R2");
    readreg(4'd3, "R2");
    // R3/R7: pre-modify byte decrement through zero
    load(4'd5, 16'h0000);
    idle_in(); exec_en = 1; byte_op = 1; dst_mode = 3'd4; dst_dec = 1; dst_base = 4'd5;
    step_vec("R3");
    readreg(4'd5, "R3");
    // R8: both operands modify one register; destination result survives
    load(4'd7, 16'h1000);
    idle_in(); exec_en = 1; src_mode = 3'd3; src_base = 4'd7; dst_mode = 3'd4; dst_base = 4'd7; dst_dec = 1;
    step_vec("R8");
    readreg(4'd7, "R8");
    // R9: modify requested without exec leaves the register alone
    idle_in(); src_mode = 3'd3; src_base = 4'd7; dst_mode = 3'd4; dst_base = 4'd8;
    step_vec("R9");
    readreg(4'd7, "R9");
    readreg(4'd8, "R9");
    // R10: test write on the same edge as an update to that register
    idle_in(); exec_en = 1; dst_mode = 3'd3; dst_base = 4'd9; tw_en = 1; tw_idx = 4'd9; tw_data = 16'hBEEF;
    step_vec("R10");
    readreg(4'd9, "R10");
    // R4/R5: shared offset register and negative literal
    load(4'd1, 16'h0004);
    load(4'd2, 16'hFFFE);
    idle_in(); off_idx = 4'd2; src_mode = 3'd5; src_base = 4'd1; dst_mode = 3'd5; dst_base = 4'd9;
    step_vec("R4");
    idle_in(); src_mode = 3'd6; src_base = 4'd1; src_lit = 6'b100000; dst_mode = 3'd6; dst_base = 4'd2; dst_lit = 6'd5;
    step_vec("R5");
    // R1/R6: direct address, indirect, register and unused modes
    idle_in(); src_mode = 3'd0; src_faddr = 16'h0A5A; dst_mode = 3'd2; dst_base = 4'd9;
    step_vec("R1");
    idle_in(); src_mode = 3'd7; src_base = 4'd2; dst_mode = 3'd1; dst_base = 4'd1;
    step_vec("R6");

    // Random mix; narrow indices often to force shared-register cases
    for (int v = 0; v < NVEC; v++) begin
      logic narrow;
      narrow = ($urandom % 2) == 0;
      exec_en = ($urandom % 4) != 0;
      byte_op = $urandom % 2;
      src_mode = 3'($urandom % 8); dst_mode = 3'($urandom % 8);
      src_base = narrow ? 4'($urandom % 4) : 4'($urandom);
      dst_base = narrow ? 4'($urandom % 4) : 4'($urandom);
      off_idx  = narrow ? 4'($urandom % 4) : 4'($urandom);
      src_dec = $urandom % 2; dst_dec = $urandom % 2;
      src_lit = 6'($urandom); dst_lit = 6'($urandom);
      src_faddr = 16'($urandom); dst_faddr = 16'($urandom);
      tw_en = ($urandom % 8) == 0;
      tw_idx = narrow ? 4'($urandom % 4) : 4'($urandom);
      tw_data = (($urandom % 2) == 0) ? 16'($urandom % 8) - 16'd4 : 16'($urandom);
      step_vec("R9");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog run did not finish actual=%h expected=%h", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule